// File: doc/BRIEF.md
# Buffered 10-bit PWM channel

This block is one pulse-width modulation channel. Its time base is an 8-bit up-counter fed by a prescaler. The prescaler runs on a quarter-rate phase of the module clock and can divide by 1, 4 or 16. Two extra low-order bits extend the counter to a 10-bit timebase. In divide-by-1 mode they come from the quarter-clock phase. In the other modes they come from the upper bits of the prescaler counter. The counter runs from zero up to a programmable period value and then wraps. The output pin goes high at the start of every period and goes low once the timebase reaches the duty value.

Software reaches the channel through a small write port. That port selects a control byte, the period, the counter itself, or a 10-bit duty value. The duty value is double-buffered. Software writes a master copy at any time. The compare logic uses a slave copy, which takes the master value only on a period wrap, so a change never cuts into a running period. An output-enable bit chooses between the PWM waveform and a fixed default level on the pin.

Top module: `pwm_channel`

## Requirements
- R1: After reset the pin is low, the counter reads 0, and the period register holds 255. With only the run bit set, the counter therefore climbs to 255 before it returns to 0.
- R2: Control bits 5:4 select the prescale. Code 00 advances the counter once every 4 clocks, code 01 once every 16 clocks, and codes 10 and 11 once every 64 clocks.
- R3: The counter counts up from 0. On the increment that follows a count equal to the period register, it returns to 0. One PWM period is therefore (period+1) x 4 x prescale clocks.
- R4: Control bit 7 is the run bit. While it is clear, the counter is held at 0 and the PWM waveform stays low.
- R5: A write to the control byte or to the counter clears the prescaler. A counter write loads the written value, and that value is seen one clock later.
- R6: A duty write updates only the master copy. The slave copy takes the master value on a period wrap and at no other time, so a duty write in the middle of a period leaves that period's high time unchanged.
- R7: The pin goes high at each period start and stays high for duty x prescale clocks. Here duty is the slave value compared against the 10-bit timebase.
- R8: A duty of 0 keeps the pin low for the whole period. A duty above the largest timebase value, (period+1) x 4 - 1, keeps it high for the whole period.
- R9: Control bit 6 enables the output. While it is clear, the pin shows control bit 0 instead of the waveform.
- R10: Write select 0 addresses the control byte (wr_data bits 7:0), 1 the period, 2 the counter and 3 the 10-bit duty value (wr_data bits 9:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; the quarter-rate phase is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 counter, 3 duty |
| wr_data | input | 10 | Write data; registers other than duty use bits 7:0 |
| pin_o | output | 1 | PWM pin level, or the default level when the output is disabled |
| tmr_o | output | 8 | Current counter value |

## Verification
A register write is sampled on one rising edge and shows its effect from the next clock on. A counter write therefore appears on tmr_o one clock later. A counter step lands on the edge that ends the last prescale slot. A duty write reaches the pin only after the next period wrap, so it can take up to a full period. The pin is decoded without delay from the counter, the phase and the slave duty value, so it changes on the same edge as the timebase. The bench therefore runs a reference model that advances on each rising edge and compares pin_o and tmr_o on the falling edge. Directed checks that measure periods and high times count falling-edge samples between pin rises.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int PS_W   = 4;
  localparam int FRAC_W = 2;

  localparam int CTRL_RUN  = 7;
  localparam int CTRL_OE   = 6;
  localparam int CTRL_PSH  = 5;
  localparam int CTRL_PSL  = 4;
  localparam int CTRL_DFLT = 0;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_PERIOD = 2'd1;
  localparam logic [1:0] SEL_TMR    = 2'd2;
  localparam logic [1:0] SEL_DUTY   = 2'd3;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV16 = 2'b10,
    PS_DIV16B = 2'b11
  } ps_sel_e;

  // last prescaler count before a counter step (ratio - 1)
  function automatic logic [PS_W-1:0] ps_last(input ps_sel_e sel);
    case (sel)
      PS_DIV1: ps_last = 4'd0;
      PS_DIV4: ps_last = 4'd3;
      default: ps_last = 4'd15;
    endcase
  endfunction

  // two low-order timebase bits for the chosen prescale
  function automatic logic [FRAC_W-1:0] tb_low(input ps_sel_e sel,
                                               input logic [1:0] qph,
                                               input logic [PS_W-1:0] cnt);
    case (sel)
      PS_DIV1: tb_low = qph;
      PS_DIV4: tb_low = cnt[1:0];
      default: tb_low = cnt[3:2];
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                clr,
  input  ps_sel_e             sel,
  output logic                tick,
  output logic [FRAC_W-1:0]   low,
  output logic [PS_W-1:0]     cnt_o
);

  logic [1:0]      qph_q;
  logic [PS_W-1:0] cnt_q;
  logic            qedge;
  logic            at_last;

  assign qedge   = (qph_q == 2'd3);
  assign at_last = (cnt_q == ps_last(sel));
  assign tick    = run & qedge & at_last & ~clr;
  assign low     = tb_low(sel, qph_q, cnt_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qph_q <= 2'd0;
    else        qph_q <= qph_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr || !run)    cnt_q <= '0;
    else if (qedge) begin
      if (at_last) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             ld,
  input  logic [TMR_W-1:0] ld_val,
  input  logic [TMR_W-1:0] period,
  output logic [TMR_W-1:0] tmr,
  output logic             wrap
);

  logic [TMR_W-1:0] tmr_q;

  assign wrap = run & tick & ~ld & (tmr_q == period);
  assign tmr  = tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (!run)   tmr_q <= '0;
    else if (ld)     tmr_q <= ld_val;
    else if (wrap)   tmr_q <= '0;
    else if (tick)   tmr_q <= tmr_q + 1'b1;
  end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] master,
  input  logic [DUTY_W-1:0] tb,
  output logic [DUTY_W-1:0] slave,
  output logic              level,
  output logic              pwm
);

  logic [DUTY_W-1:0] slave_q;
  logic              level_q;
  logic              hit;

  assign hit   = (tb == slave_q);
  assign slave = slave_q;
  assign level = level_q;
  assign pwm   = level_q & ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     slave_q <= '0;
    else if (wrap)  slave_q <= master;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level_q <= 1'b0;
    else if (!run)   level_q <= 1'b0;
    else if (wrap)   level_q <= (master != '0);
    else if (hit)    level_q <= 1'b0;
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int TMR_W = 8,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DUTY_W-1:0] wr_data,
  output logic              pin_o,
  output logic [TMR_W-1:0]  tmr_o
);

  logic              run_q, oe_q, dflt_q;
  ps_sel_e           ps_q;
  logic [TMR_W-1:0]  period_q;
  logic [DUTY_W-1:0] master_q;

  logic              wr_ctrl, wr_tmr, ps_clr;
  logic              tick, wrap;
  logic [FRAC_W-1:0] tb_lo;
  logic [PS_W-1:0]   ps_cnt;
  logic [TMR_W-1:0]  tmr_q;
  logic [DUTY_W-1:0] tb, slave_q;
  logic              level_q, pwm;

  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_tmr  = wr_en && (wr_sel == SEL_TMR);
  assign ps_clr  = wr_ctrl | wr_tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      oe_q   <= 1'b0;
      dflt_q <= 1'b0;
      ps_q   <= PS_DIV1;
    end else if (wr_ctrl) begin
      run_q  <= wr_data[CTRL_RUN];
      oe_q   <= wr_data[CTRL_OE];
      dflt_q <= wr_data[CTRL_DFLT];
      ps_q   <= ps_sel_e'(wr_data[CTRL_PSH:CTRL_PSL]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            period_q <= '1;
    else if (wr_en && wr_sel == SEL_PERIOD) period_q <= wr_data[TMR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          master_q <= '0;
    else if (wr_en && wr_sel == SEL_DUTY) master_q <= wr_data;
  end

  pwm_prescaler u_ps (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .clr   (ps_clr),
    .sel   (ps_q),
    .tick  (tick),
    .low   (tb_lo),
    .cnt_o (ps_cnt)
  );

  pwm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .tick   (tick),
    .ld     (wr_tmr),
    .ld_val (wr_data[TMR_W-1:0]),
    .period (period_q),
    .tmr    (tmr_q),
    .wrap   (wrap)
  );

  assign tb = {tmr_q, tb_lo};

  pwm_compare #(.DUTY_W(DUTY_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .wrap   (wrap),
    .master (master_q),
    .tb     (tb),
    .slave  (slave_q),
    .level  (level_q),
    .pwm    (pwm)
  );

  assign pin_o = oe_q ? pwm : dflt_q;
  assign tmr_o = tmr_q;

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
  parameter int TMR_W = 8,
  parameter int PS_W = 4,
  localparam int DUTY_W = TMR_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              tick,
  input logic              wrap,
  input logic              ps_clr,
  input logic [PS_W-1:0]   ps_cnt,
  input logic [TMR_W-1:0]  tmr_q,
  input logic [DUTY_W-1:0] master_q,
  input logic [DUTY_W-1:0] slave_q,
  input logic              level_q
);

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_wrap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (tmr_q == '0));

  assert_off_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (tmr_q == '0) && !level_q);

  assert_ps_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ps_clr |=> (ps_cnt == '0));

  assert_slave_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(slave_q));

  assert_slave_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (slave_q == $past(master_q)));

  assert_set_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && master_q != '0) |=> level_q);

  assert_zero_duty_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_q == '0) |-> !level_q);

endmodule

bind pwm_channel pwm_channel_chk #(.TMR_W(TMR_W), .PS_W(pwm_pkg::PS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .tick     (tick),
  .wrap     (wrap),
  .ps_clr   (ps_clr),
  .ps_cnt   (ps_cnt),
  .tmr_q    (tmr_q),
  .master_q (master_q),
  .slave_q  (slave_q),
  .level_q  (level_q)
);

// File: tb/sim_pwm_channel.sv
`timescale 1ns/1ps
module sim_pwm_channel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [9:0] wr_data = 10'd0;
  logic       pin_o;
  logic [7:0] tmr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_channel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pin_o(pin_o), .tmr_o(tmr_o)
  );

  // behavioural reference state
  int m_q = 0, m_p = 0, m_t = 0, m_pr = 255, m_master = 0, m_slave = 0;
  int m_ps = 0;
  bit m_run = 0, m_oe = 0, m_dflt = 0, m_lvl = 0;

  function automatic int ratio_last(int ps);
    if (ps == 0) return 0;
    if (ps == 1) return 3;
    return 15;
  endfunction

  function automatic int m_tb();
    int lo;
    if (m_ps == 0) lo = m_q;
    else if (m_ps == 1) lo = m_p % 4;
    else lo = m_p / 4;
    return m_t * 4 + lo;
  endfunction

  function automatic bit m_pin();
    if (!m_oe) return m_dflt;
    return m_lvl && (m_tb() != m_slave);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = 0; m_p = 0; m_t = 0; m_pr = 255; m_master = 0; m_slave = 0;
      m_ps = 0; m_run = 0; m_oe = 0; m_dflt = 0; m_lvl = 0;
    end else begin
      int tb, last, d;
      bit clr, qe, tk, ldt, wr;
      tb   = m_tb();
      last = ratio_last(m_ps);
      d    = int'(wr_data);
      clr  = wr_en && (wr_sel == 2'd0 || wr_sel == 2'd2);
      ldt  = wr_en && wr_sel == 2'd2;
      qe   = (m_q == 3);
      tk   = m_run && qe && (m_p == last) && !clr;
      wr   = tk && !ldt && (m_t == m_pr);
      if (!m_run) m_lvl = 0;
      else if (wr) m_lvl = (m_master != 0);
      else if (tb == m_slave) m_lvl = 0;
      if (wr) m_slave = m_master;
      if (!m_run) m_t = 0;
      else if (ldt) m_t = d % 256;
      else if (wr) m_t = 0;
      else if (tk) m_t = (m_t + 1) % 256;
      if (clr || !m_run) m_p = 0;
      else if (qe) m_p = (m_p == last) ? 0 : m_p + 1;
      m_q = (m_q + 1) % 4;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            m_run = d[7]; m_oe = d[6]; m_ps = (d / 16) % 4; m_dflt = d[0];
          end
          2'd1: m_pr = d % 256;
          2'd3: m_master = d;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pin_o !== m_pin() || int'(tmr_o) != m_t) begin
        errors++;
        $display("FAIL %s model compare at cycle %0d: pin=%0b tmr=%0d expected pin=%0b tmr=%0d",
                 cur_req, cycles, pin_o, tmr_o, m_pin(), m_t);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 10'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    logic prev;
    @(negedge clk);
    prev = pin_o;
    forever begin
      @(negedge clk);
      if (pin_o && !prev) break;
      prev = pin_o;
    end
  endtask

  // from a rise, count the high samples and the samples up to the next rise
  task automatic measure(output int hi, output int per);
    logic prev;
    wait_rise();
    hi = 1; per = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      if (pin_o && !prev) break;
      hi += int'(pin_o);
      per++;
      prev = pin_o;
    end
  endtask

  task automatic hold_level(string req, logic lvl, int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_o !== lvl) bad++;
    end
    check(req, bad, 0, "samples off the held level");
  endtask

  initial begin
    int hi, per, seen, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", int'(pin_o), 0, "pin after reset");
    check("R1", int'(tmr_o), 0, "counter after reset");
    // R1: period register resets to 255
    wr(2'd0, 8'h80);
    seen = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (tmr_o == 8'd255) seen = 1;
      if (seen == 1 && tmr_o == 8'd0) begin seen = 2; break; end
    end
    check("R1", seen, 2, "counter reached 255 then wrapped");

    // R3 / R7 / R10: divide-by-1
    cur_req = "R3";
    wr(2'd1, 9);
    wr(2'd3, 20);
    wr(2'd0, 8'hC0);
    measure(hi, per);
    check("R3", per, 40, "period clocks at 1:1");
    check("R7", hi, 20, "high clocks at 1:1");

    // R2: divide-by-4 and divide-by-16
    cur_req = "R2";
    wr(2'd0, 8'hD0);
    measure(hi, per);
    check("R2", per, 160, "period clocks at 1:4");
    check("R7", hi, 80, "high clocks at 1:4");
    wr(2'd0, 8'hE0);
    measure(hi, per);
    check("R2", per, 640, "period clocks at 1:16");
    check("R7", hi, 320, "high clocks at 1:16");
    wr(2'd0, 8'hF0);
    measure(hi, per);
    check("R2", per, 640, "period clocks with code 11");

    // R8: duty extremes
    cur_req = "R8";
    wr(2'd0, 8'hC0);
    wr(2'd3, 0);
    repeat (100) @(negedge clk);
    hold_level("R8", 1'b0, 80);
    wr(2'd3, 50);
    repeat (100) @(negedge clk);
    hold_level("R8", 1'b1, 80);

    // R6: mid-period duty write
    cur_req = "R6";
    wr(2'd3, 10);
    repeat (100) @(negedge clk);
    wait_rise();
    hi = 1;
    fork
      begin
        for (int i = 0; i < 36; i++) begin
          @(negedge clk);
          hi += int'(pin_o);
        end
      end
      begin
        repeat (4) @(negedge clk);
        wr(2'd3, 30);
      end
    join
    check("R6", hi, 10, "high clocks of period with mid-period write");
    measure(hi, per);
    check("R6", hi, 30, "high clocks after the write took effect");

    // R9: output disable shows default level
    cur_req = "R9";
    wr(2'd0, 8'h81);
    hold_level("R9", 1'b1, 50);
    wr(2'd0, 8'h80);
    hold_level("R9", 1'b0, 50);

    // R4: run bit clear
    cur_req = "R4";
    wr(2'd0, 8'h40);
    @(negedge clk);
    check("R4", int'(tmr_o), 0, "counter with run clear");
    hold_level("R4", 1'b0, 40);
    check("R4", int'(tmr_o), 0, "counter still 0 with run clear");

    // R5: counter write loads and clears the prescaler
    cur_req = "R5";
    wr(2'd1, 200);
    wr(2'd0, 8'hD0);
    repeat (30) @(negedge clk);
    wr(2'd2, 3);
    check("R5", int'(tmr_o), 3, "counter right after write");
    cnt = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tmr_o != 8'd3) break;
      cnt++;
    end
    check("R5", int'(cnt >= 13 && cnt <= 16), 1, "clocks before next step within 13..16");
    check("R5", int'(tmr_o), 4, "counter after first step");

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule